// File: doc/BRIEF.md
# Memory-to-Memory Block Copy Engine

This block copies a run of bytes from one memory region to another with no processor involvement once started. It is built from a pair of DMA channels. The first channel holds the source address. The second holds the destination address and the transfer count. A move starts when the copy mode is enabled, the destination channel is not masked, and a software or hardware request arrives on the first channel. The block then raises its bus request and waits for the grant.

Once the bus is granted, each byte takes two four-clock cycles. In the read cycle the block fetches the byte from the source address into an internal holding register. In the write cycle it stores that byte at the destination address. Each address steps up or down on its own after its cycle. The bus is kept for the whole move. Only the destination count decides when the move is over. A count value of N moves N+1 bytes. When the last write finishes, an end-of-process pulse is issued, a terminal-count flag is set, and the destination channel is masked. If autoreload is selected, the channel is not masked. Instead its working addresses and count are restored from the values that were loaded. An external end request stops the move after the write cycle that is in progress.

The load strobe is honoured only while the block is idle. It sets both the base and working copies of the addresses and count, and it clears the flag and the mask.

Top module: `blk_mover`

## Requirements
- R1: While copy mode is disabled (`ld_copy_en`=0 at the last load), requests on `sw_req` or `hw_req` never raise `hrq`.
- R2: An accepted request raises `hrq` on the next cycle. The first read cycle begins on the cycle after `hlda` is sampled high. `hrq` stays high without a gap until the move ends.
- R3: A read cycle lasts 4 clocks with `mem_addr` equal to the source address. `mem_rd` is high in its 2nd and 3rd clocks only. The source address then steps by one, upward when `ld_src_down`=0 and downward when it is 1.
- R4: The write cycle follows the read cycle. It lasts 4 clocks with `mem_addr` equal to the destination address and `mem_wr` high in its 2nd and 3rd clocks. `data_out` carries the byte that was read. The destination address then steps by one, upward when `ld_dst_down`=0 and downward when it is 1.
- R5: A count of N moves exactly N+1 bytes. `eop_out` is high only in the 4th clock of the write cycle in which the count wraps from 0 to all ones.
- R6: `tc_flag` is set when a move ends by terminal count and is cleared by a load.
- R7: `mask1` is 1 after reset. It is set when a move ends with `ld_auto`=0 and cleared by a load. While it is 1, requests never raise `hrq`.
- R8: With `ld_auto`=1, the end of a move restores the source address, destination address and count to their loaded values and leaves `mask1` at 0.
- R9: `hrq` falls on the cycle after the final write cycle. `data_out` keeps the last byte moved while the block is idle.
- R10: `eop_in` seen high during a move ends it after the current write cycle completes. In that case `tc_flag` is not set and `eop_out` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ld | input | 1 | Load strobe for setup values, taken only when idle |
| ld_copy_en | input | 1 | Enables the memory-to-memory pairing |
| ld_src | input | 16 | Source start address |
| ld_dst | input | 16 | Destination start address |
| ld_cnt | input | 16 | Byte count minus one |
| ld_src_down | input | 1 | Source address steps downward |
| ld_dst_down | input | 1 | Destination address steps downward |
| ld_auto | input | 1 | Autoreload at the end of a move |
| sw_req | input | 1 | Software start request |
| hw_req | input | 1 | Hardware start request |
| hrq | output | 1 | Bus request |
| hlda | input | 1 | Bus grant |
| mem_addr | output | 16 | Memory address (0 when not transferring) |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| data_in | input | 8 | Read data from memory |
| data_out | output | 8 | Write data, the held byte |
| eop_in | input | 1 | External end request |
| eop_out | output | 1 | End-of-process at terminal count |
| tc_flag | output | 1 | Terminal-count status |
| mask1 | output | 1 | Destination channel mask |

## Verification
A phase counter that is off by one shows up within a single clock. The strobes would fall on the wrong clocks, or `mem_addr` would switch between source and destination at the wrong time. A bad working address or count stays hidden until the next cycle of that kind. It then appears as a wrong `mem_addr`, as an early or late `eop_out`, or as a wrong byte left in the bench memory. A lost reload or a lost mask update appears only when the next request is made. Because of this, the bench compares every output against a reference model on every clock, and it also checks the copied memory after each move.

// File: rtl/blk_mover.sv
module blk_mover #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic          ld_copy_en,
  input  logic [AW-1:0] ld_src,
  input  logic [AW-1:0] ld_dst,
  input  logic [CW-1:0] ld_cnt,
  input  logic          ld_src_down,
  input  logic          ld_dst_down,
  input  logic          ld_auto,
  input  logic          sw_req,
  input  logic          hw_req,
  output logic          hrq,
  input  logic          hlda,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  input  logic [DW-1:0] data_in,
  output logic [DW-1:0] data_out,
  input  logic          eop_in,
  output logic          eop_out,
  output logic          tc_flag,
  output logic          mask1
);
  localparam logic [1:0] ST_IDLE = 2'd0, ST_REQ = 2'd1, ST_XFER = 2'd2;
  localparam logic [2:0] PH_LAST = 3'd7, PH_GRAB = 3'd2, PH_RDEND = 3'd3;

  logic [1:0]    st;
  logic [2:0]    ph;
  logic          copy_on, src_down, dst_down, auto_on, eop_pend;
  logic [AW-1:0] src_base, dst_base, src_cur, dst_cur;
  logic [CW-1:0] cnt_base, cnt_cur;
  logic [DW-1:0] hold;

  wire xfer   = (st == ST_XFER);
  wire in_wr  = ph[2];
  wire strobe = (ph[1:0] == 2'd1) || (ph[1:0] == 2'd2);
  wire tc_hit = (cnt_cur == '0);
  wire finish = xfer && (ph == PH_LAST) && (tc_hit || eop_pend || eop_in);

  assign hrq      = (st != ST_IDLE);
  assign mem_addr = !xfer ? '0 : (in_wr ? dst_cur : src_cur);
  assign mem_rd   = xfer && !in_wr && strobe;
  assign mem_wr   = xfer && in_wr && strobe;
  assign eop_out  = xfer && (ph == PH_LAST) && tc_hit;
  assign data_out = hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE;  ph <= '0;
      copy_on <= 1'b0; src_down <= 1'b0; dst_down <= 1'b0; auto_on <= 1'b0;
      eop_pend <= 1'b0; tc_flag <= 1'b0; mask1 <= 1'b1;
      src_base <= '0; dst_base <= '0; cnt_base <= '0;
      src_cur <= '0;  dst_cur <= '0;  cnt_cur <= '0;
      hold <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (ld) begin
            copy_on <= ld_copy_en; src_down <= ld_src_down;
            dst_down <= ld_dst_down; auto_on <= ld_auto;
            src_base <= ld_src; dst_base <= ld_dst; cnt_base <= ld_cnt;
            src_cur <= ld_src;  dst_cur <= ld_dst;  cnt_cur <= ld_cnt;
            tc_flag <= 1'b0; mask1 <= 1'b0;
          end else if (copy_on && !mask1 && (sw_req || hw_req)) begin
            st <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (hlda) begin
            st <= ST_XFER;
            ph <= '0;
          end
        end
        ST_XFER: begin
          ph <= ph + 3'd1;
          if (eop_in) eop_pend <= 1'b1;
          if (ph == PH_GRAB) hold <= data_in;
          if (ph == PH_RDEND) src_cur <= src_down ? src_cur - 1'b1 : src_cur + 1'b1;
          if (ph == PH_LAST) begin
            dst_cur <= dst_down ? dst_cur - 1'b1 : dst_cur + 1'b1;
            cnt_cur <= cnt_cur - 1'b1;
          end
          if (finish) begin
            st <= ST_IDLE;
            eop_pend <= 1'b0;
            if (tc_hit) tc_flag <= 1'b1;
            if (auto_on) begin
              src_cur <= src_base; dst_cur <= dst_base; cnt_cur <= cnt_base;
            end else begin
              mask1 <= 1'b1;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/blk_mover_chk.sv
module blk_mover_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ld,
  input logic          copy_on,
  input logic          hrq,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic          eop_out,
  input logic          tc_flag,
  input logic          mask1,
  input logic [DW-1:0] data_out
);
  p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  p_strobe_needs_bus_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> hrq);

  p_eop_releases_r5: assert property (@(posedge clk) disable iff (!rst_n)
    eop_out |=> !hrq);

  p_tc_from_eop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tc_flag) |-> $past(eop_out));

  p_disabled_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!copy_on && !hrq) |=> !hrq);

  p_mask_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mask1 && !hrq && !ld) |=> !hrq);

  p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!hrq && $past(!hrq)) |-> $stable(data_out));
endmodule

bind blk_mover blk_mover_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .ld(ld), .copy_on(copy_on), .hrq(hrq),
  .mem_rd(mem_rd), .mem_wr(mem_wr), .eop_out(eop_out), .tc_flag(tc_flag),
  .mask1(mask1), .data_out(data_out)
);

// File: tb/blk_mover_tb.sv
module blk_mover_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ld = 0, ld_copy_en = 0, ld_src_down = 0, ld_dst_down = 0, ld_auto = 0;
  logic [15:0] ld_src = 0, ld_dst = 0, ld_cnt = 0;
  logic sw_req = 0, hw_req = 0, hlda = 0, eop_in = 0;
  logic hrq, mem_rd, mem_wr, eop_out, tc_flag, mask1;
  logic [15:0] mem_addr;
  logic [7:0] data_in, data_out;
  logic [7:0] mem [256];

  int total = 0, bad = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign data_in = mem[mem_addr[7:0]];

  blk_mover dut_i (
    .clk(clk), .rst_n(rst_n), .ld(ld), .ld_copy_en(ld_copy_en),
    .ld_src(ld_src), .ld_dst(ld_dst), .ld_cnt(ld_cnt),
    .ld_src_down(ld_src_down), .ld_dst_down(ld_dst_down), .ld_auto(ld_auto),
    .sw_req(sw_req), .hw_req(hw_req), .hrq(hrq), .hlda(hlda),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .data_in(data_in), .data_out(data_out), .eop_in(eop_in),
    .eop_out(eop_out), .tc_flag(tc_flag), .mask1(mask1)
  );

  function automatic logic [7:0] init_val(int a);
    return 8'((a * 7 + 3) & 255);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= init_val(i);
    end else if (mem_wr) begin
      mem[mem_addr[7:0]] <= data_out;
    end
  end

  // Behavioural reference: mode 0 idle, 1 waiting for grant, 2 moving
  int m_mode, m_tick, m_src, m_dst, m_cnt, b_src, b_dst, b_cnt;
  bit m_en, m_sdn, m_ddn, m_auto, m_tc, m_mask, m_pend;
  logic [7:0] m_tmp;
  logic [7:0] mmem [256];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_tick = 0; m_src = 0; m_dst = 0; m_cnt = 0;
      b_src = 0; b_dst = 0; b_cnt = 0; m_en = 0; m_sdn = 0; m_ddn = 0;
      m_auto = 0; m_tc = 0; m_mask = 1; m_pend = 0; m_tmp = 0;
      for (int i = 0; i < 256; i++) mmem[i] = init_val(i);
    end else if (m_mode == 0) begin
      if (ld) begin
        m_en = ld_copy_en; m_sdn = ld_src_down; m_ddn = ld_dst_down; m_auto = ld_auto;
        b_src = ld_src; b_dst = ld_dst; b_cnt = ld_cnt;
        m_src = b_src; m_dst = b_dst; m_cnt = b_cnt; m_tc = 0; m_mask = 0;
      end else if (m_en && !m_mask && (sw_req || hw_req)) m_mode = 1;
    end else if (m_mode == 1) begin
      if (hlda) begin m_mode = 2; m_tick = 0; end
    end else begin
      bit stop;
      stop = (m_tick == 7) && (m_cnt == 0 || m_pend || eop_in);
      if (eop_in) m_pend = 1;
      if (m_tick == 2) m_tmp = mmem[m_src & 255];
      if (m_tick == 3) m_src = (m_sdn ? m_src - 1 : m_src + 1) & 16'hFFFF;
      if (m_tick == 7) begin
        mmem[m_dst & 255] = m_tmp;
        if (stop && m_cnt == 0) m_tc = 1;
        m_dst = (m_ddn ? m_dst - 1 : m_dst + 1) & 16'hFFFF;
        m_cnt = (m_cnt - 1) & 16'hFFFF;
      end
      m_tick = (m_tick + 1) % 8;
      if (stop) begin
        m_mode = 0; m_pend = 0;
        if (m_auto) begin m_src = b_src; m_dst = b_dst; m_cnt = b_cnt; end
        else m_mask = 1;
      end
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      bit mv, wrp;
      int e_addr;
      mv = (m_mode == 2);
      wrp = m_tick >= 4;
      e_addr = !mv ? 0 : (wrp ? m_dst : m_src);
      chk(hrq == (m_mode != 0), "R2 hrq", hrq, m_mode != 0);
      chk(mem_addr == e_addr, wrp ? "R4 mem_addr" : "R3 mem_addr", mem_addr, e_addr);
      chk(mem_rd == (mv && !wrp && (m_tick == 1 || m_tick == 2)), "R3 mem_rd", mem_rd, 0);
      chk(mem_wr == (mv && wrp && (m_tick == 5 || m_tick == 6)), "R4 mem_wr", mem_wr, 0);
      chk(eop_out == (mv && m_tick == 7 && m_cnt == 0), "R5 eop_out", eop_out, 0);
      chk(tc_flag == m_tc, "R6 tc_flag", tc_flag, m_tc);
      chk(mask1 == m_mask, "R7 mask1", mask1, m_mask);
      chk(data_out == m_tmp, "R9 data_out", data_out, m_tmp);
    end
    hlda <= hrq;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic load(int s, int d, int c, bit en, bit sdn, bit ddn, bit au);
    @(negedge clk);
    ld = 1; ld_copy_en = en; ld_src = 16'(s); ld_dst = 16'(d); ld_cnt = 16'(c);
    ld_src_down = sdn; ld_dst_down = ddn; ld_auto = au;
    @(negedge clk);
    ld = 0;
  endtask

  task automatic pulse_sw;
    @(negedge clk); sw_req = 1;
    @(negedge clk); sw_req = 0;
  endtask

  task automatic wait_done;
    while (!hrq) @(negedge clk);
    while (hrq) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic stay_idle(string tag);
    bit seen = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (hrq) seen = 1;
    end
    chk(!seen, tag, seen, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(hrq == 0 && mem_rd == 0 && mem_wr == 0, "R2 reset idle", hrq, 0);
    chk(mask1 == 1, "R7 reset mask", mask1, 1);

    // Four bytes, both addresses upward
    load(16'h10, 16'h80, 3, 1, 0, 0, 0);
    pulse_sw();
    wait_done();
    for (int i = 0; i < 4; i++)
      chk(mem[8'h80 + i] == init_val(16'h10 + i), "R5 copied byte", mem[8'h80 + i], init_val(16'h10 + i));
    chk(mem[8'h84] == init_val(16'h84), "R5 no extra byte", mem[8'h84], init_val(16'h84));
    chk(tc_flag == 1, "R6 tc set", tc_flag, 1);
    chk(mask1 == 1, "R7 mask set", mask1, 1);
    chk(data_out == init_val(16'h13), "R9 last byte held", data_out, init_val(16'h13));

    // Masked channel ignores a request
    pulse_sw();
    stay_idle("R7 masked request ignored");

    // Single byte, hardware request, source downward
    load(16'h30, 16'h90, 0, 1, 1, 0, 0);
    chk(tc_flag == 0, "R6 tc cleared by load", tc_flag, 0);
    @(negedge clk); hw_req = 1;
    while (!hrq) @(negedge clk);
    hw_req = 0;
    wait_done();
    chk(mem[8'h90] == init_val(16'h30), "R3 single byte", mem[8'h90], init_val(16'h30));
    chk(mem[8'h91] == init_val(16'h91), "R5 count zero one byte", mem[8'h91], init_val(16'h91));

    // Disabled copy mode
    load(16'h30, 16'hB0, 2, 0, 0, 0, 0);
    pulse_sw();
    stay_idle("R1 disabled request ignored");

    // Autoreload, destination downward, two runs
    load(16'h40, 16'hA0, 1, 1, 0, 1, 1);
    pulse_sw();
    wait_done();
    chk(mem[8'hA0] == init_val(16'h40), "R4 down byte0", mem[8'hA0], init_val(16'h40));
    chk(mem[8'h9F] == init_val(16'h41), "R4 down byte1", mem[8'h9F], init_val(16'h41));
    chk(mask1 == 0, "R8 mask stays clear", mask1, 0);
    chk(tc_flag == 1, "R6 tc after auto", tc_flag, 1);
    pulse_sw();
    while (!mem_rd) @(negedge clk);
    chk(mem_addr == 16'h40, "R8 reloaded source", mem_addr, 16'h40);
    wait_done();
    chk(mem[8'h9F] == init_val(16'h41), "R8 second run", mem[8'h9F], init_val(16'h41));

    // External end during the second write
    load(16'h50, 16'hC0, 7, 1, 0, 0, 0);
    pulse_sw();
    while (!mem_wr) @(negedge clk);
    while (mem_wr) @(negedge clk);
    while (!mem_wr) @(negedge clk);
    eop_in = 1;
    @(negedge clk); eop_in = 0;
    wait_done();
    chk(mem[8'hC1] == init_val(16'h51), "R10 current write done", mem[8'hC1], init_val(16'h51));
    chk(mem[8'hC2] == init_val(16'hC2), "R10 stopped early", mem[8'hC2], init_val(16'hC2));
    chk(tc_flag == 0, "R10 no tc", tc_flag, 0);
    chk(mask1 == 1, "R7 mask after eop", mask1, 1);
    chk(data_out == init_val(16'h51), "R9 held byte", data_out, init_val(16'h51));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule